// File: doc/BRIEF.md
# Fixed-Bank Cartridge Address Mapper

This block sits between a console's two buses and the memories on a plug-in cartridge. It has no bank switching. On the processor side it watches the upper half of the 64 KB address space. It tells the cartridge whether it owns each access and works out the offset into program ROM. When only one 16 KB program bank is fitted, that bank appears twice: once at 0x8000 and again at 0xC000. On the video side it claims reads of the 8 KB pattern region and passes the address straight through as the character ROM offset. It refuses writes to that region, because character storage is read-only.

Both halves are registered. A claim flag and its offset appear on the outputs one clock after the address and strobes are presented. The cartridge glue uses the claim flags to take an access away from the console's own devices. It uses the offsets to index its ROM arrays. The number of program banks comes from a static configuration input, which is normally set when the cartridge image is loaded.

Top module: `cart_addr_mapper`

## Requirements
- R1: The processor claim is 1 only when the read or write strobe is high and the address is in 0x8000–0xFFFF (address bit 15 set). Every output shows the inputs that were sampled at the previous rising clock edge.
- R2: When `prg_bank_cnt` is 2 or 3 (32 KB fitted), a claimed processor access gives `prg_ofs` = address AND 0x7FFF.
- R3: When `prg_bank_cnt` is 0 or 1 (16 KB fitted), a claimed access gives `prg_ofs` = address AND 0x3FFF. Addresses 0xC000+n and 0x8000+n therefore give the same offset.
- R4: A processor write in 0x8000–0xFFFF is claimed and gives the same offset as a read of that address. A following read of that address still gives the same offset.
- R5: A video read (read strobe high, write strobe low) of an address in 0x0000–0x1FFF is claimed, and `chr_ofs` equals the address bits 12:0.
- R6: A video access with the write strobe high is never claimed, even when the read strobe is also high.
- R7: A video address in 0x2000–0x3FFF (bit 13 set) is never claimed.
- R8: Whenever a claim flag is 0, its offset output is 0.
- R9: While `rst_n` is low, both claim flags and both offsets are 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor bus address |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| prg_bank_cnt | input | 2 | Number of fitted 16 KB program banks |
| vid_addr | input | 14 | Video bus address |
| vid_rd | input | 1 | Video read strobe |
| vid_wr | input | 1 | Video write strobe |
| prg_claim | output | 1 | Cartridge owns the processor access |
| prg_ofs | output | 15 | Program ROM offset |
| chr_claim | output | 1 | Cartridge owns the video access |
| chr_ofs | output | 13 | Character ROM offset |

## Verification
Each output register is reloaded from the current inputs on every edge, so a wrong claim or offset is visible at the ports on the very next clock and does not persist. The serious failures are a mirror mask that is wrong for the fitted bank count, a claim on a character write or above the pattern region, and a stale offset left on a cycle with no claim. The directed tests place addresses on both sides of each window edge and on both copies of the mirrored program bank, so each of these faults shows as a wrong flag or offset one cycle after the stimulus.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

    localparam int CPU_ADDR_W = 16;
    localparam int VID_ADDR_W = 14;
    localparam int PRG_BANK_W = 14;            // 16 KB per program bank
    localparam int PRG_OFS_W  = PRG_BANK_W + 1; // two banks at most
    localparam int CHR_OFS_W  = 13;            // one 8 KB character bank
    localparam int BANK_CNT_W = 2;

    typedef enum logic {
        PRG_SIZE_SINGLE = 1'b0,
        PRG_SIZE_DOUBLE = 1'b1
    } prg_size_e;

    // two or more fitted banks fill the whole window, otherwise mirror
    function automatic prg_size_e size_from_count(input logic [BANK_CNT_W-1:0] cnt);
        return (cnt >= 2) ? PRG_SIZE_DOUBLE : PRG_SIZE_SINGLE;
    endfunction

endpackage

// File: rtl/cart_prg_map.sv
module cart_prg_map
    import cart_map_pkg::*;
#(
    parameter int ADDR_W = CPU_ADDR_W,
    parameter int OFS_W  = PRG_OFS_W,
    parameter int CNT_W  = BANK_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [CNT_W-1:0]  bank_cnt,
    output logic              claim_o,
    output logic [OFS_W-1:0]  ofs_o
);

    localparam int WIN_BIT  = ADDR_W - 1;   // upper half of the space
    localparam int MIRR_BIT = OFS_W - 1;    // dropped when one bank fitted

    typedef struct packed {
        logic             claim;
        logic [OFS_W-1:0] ofs;
    } prg_state_t;

    prg_state_t st_d, st_q;
    prg_size_e  size_d;

    always_comb begin
        size_d   = size_from_count(bank_cnt);
        st_d     = '0;
        st_d.claim = addr[WIN_BIT] & (rd | wr);
        if (st_d.claim) begin
            st_d.ofs = addr[OFS_W-1:0];
            if (size_d == PRG_SIZE_SINGLE) begin
                st_d.ofs[MIRR_BIT] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign claim_o = st_q.claim;
    assign ofs_o   = st_q.ofs;

    AST_PRG_CLAIM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |-> ($past(addr[WIN_BIT]) && ($past(rd) || $past(wr)))); // R1

    AST_PRG_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |-> (ofs_o[MIRR_BIT-1:0] == $past(addr[MIRR_BIT-1:0]))); // R2

    AST_PRG_MIRROR_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_o && ($past(bank_cnt) < 2)) |-> !ofs_o[MIRR_BIT]); // R3

    AST_PRG_WRITE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr) && $past(addr[WIN_BIT])) |-> claim_o); // R4

    AST_PRG_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !claim_o |-> (ofs_o == '0)); // R8

endmodule

// File: rtl/cart_chr_map.sv
module cart_chr_map
    import cart_map_pkg::*;
#(
    parameter int ADDR_W = VID_ADDR_W,
    parameter int OFS_W  = CHR_OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              claim_o,
    output logic [OFS_W-1:0]  ofs_o
);

    localparam int HI_W = ADDR_W - OFS_W;   // bits above the pattern region

    typedef struct packed {
        logic             claim;
        logic [OFS_W-1:0] ofs;
    } chr_state_t;

    chr_state_t       st_d, st_q;
    logic             in_region;

    always_comb begin
        in_region  = (addr[ADDR_W-1:OFS_W] == '0);
        st_d       = '0;
        // read-only space: any write strobe withdraws the claim
        st_d.claim = rd & ~wr & in_region;
        if (st_d.claim) begin
            st_d.ofs = addr[OFS_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign claim_o = st_q.claim;
    assign ofs_o   = st_q.ofs;

    AST_CHR_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |-> (ofs_o == $past(addr[OFS_W-1:0]))); // R5

    AST_CHR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr) |-> !claim_o); // R6

    AST_CHR_ABOVE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(addr[ADDR_W-1:OFS_W]) != {HI_W{1'b0}}) |-> !claim_o); // R7

    AST_CHR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !claim_o |-> (ofs_o == '0)); // R8

endmodule

// File: rtl/cart_addr_mapper.sv
module cart_addr_mapper
    import cart_map_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CPU_ADDR_W-1:0] cpu_addr,
    input  logic                  cpu_rd,
    input  logic                  cpu_wr,
    input  logic [BANK_CNT_W-1:0] prg_bank_cnt,
    input  logic [VID_ADDR_W-1:0] vid_addr,
    input  logic                  vid_rd,
    input  logic                  vid_wr,
    output logic                  prg_claim,
    output logic [PRG_OFS_W-1:0]  prg_ofs,
    output logic                  chr_claim,
    output logic [CHR_OFS_W-1:0]  chr_ofs
);

    cart_prg_map #(
        .ADDR_W (CPU_ADDR_W),
        .OFS_W  (PRG_OFS_W),
        .CNT_W  (BANK_CNT_W)
    ) i_prg (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (cpu_addr),
        .rd       (cpu_rd),
        .wr       (cpu_wr),
        .bank_cnt (prg_bank_cnt),
        .claim_o  (prg_claim),
        .ofs_o    (prg_ofs)
    );

    cart_chr_map #(
        .ADDR_W (VID_ADDR_W),
        .OFS_W  (CHR_OFS_W)
    ) i_chr (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (vid_addr),
        .rd      (vid_rd),
        .wr      (vid_wr),
        .claim_o (chr_claim),
        .ofs_o   (chr_ofs)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!prg_claim && !chr_claim && prg_ofs == '0 && chr_ofs == '0)); // R9

endmodule

// File: tb/test_cart_addr_mapper.sv
`timescale 1ns/1ps
module test_cart_addr_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [1:0]  prg_bank_cnt = 2'd2;
    logic [13:0] vid_addr = '0;
    logic        vid_rd = 1'b0;
    logic        vid_wr = 1'b0;
    logic        prg_claim;
    logic [14:0] prg_ofs;
    logic        chr_claim;
    logic [12:0] chr_ofs;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cart_addr_mapper i_cart_addr_mapper (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .prg_bank_cnt(prg_bank_cnt),
        .vid_addr(vid_addr), .vid_rd(vid_rd), .vid_wr(vid_wr),
        .prg_claim(prg_claim), .prg_ofs(prg_ofs),
        .chr_claim(chr_claim), .chr_ofs(chr_ofs)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // drive at a falling edge, result is registered at the next rising edge,
    // sample at the falling edge after it
    task automatic cpu_step(input logic [15:0] a, input logic r, input logic w,
                            input logic [1:0] bc);
        @(negedge clk);
        cpu_addr = a; cpu_rd = r; cpu_wr = w; prg_bank_cnt = bc;
        @(negedge clk);
    endtask

    task automatic vid_step(input logic [13:0] a, input logic r, input logic w);
        @(negedge clk);
        vid_addr = a; vid_rd = r; vid_wr = w;
        @(negedge clk);
    endtask

    task automatic expect_prg(input string req, input int claim, input int ofs);
        chk(req, "prg_claim", int'(prg_claim), claim);
        chk(req, "prg_ofs", int'(prg_ofs), ofs);
    endtask

    task automatic expect_chr(input string req, input int claim, input int ofs);
        chk(req, "chr_claim", int'(chr_claim), claim);
        chk(req, "chr_ofs", int'(chr_ofs), ofs);
    endtask

    task automatic t_reset;
        @(negedge clk);
        cpu_addr = 16'h9000; cpu_rd = 1'b1; vid_addr = 14'h0123; vid_rd = 1'b1;
        @(negedge clk);
        expect_prg("R9", 0, 0);
        expect_chr("R9", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_prg("R1", 1, 16'h1000);
        expect_chr("R5", 1, 16'h0123);
        cpu_rd = 1'b0; vid_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_prg_double;
        cpu_step(16'h8000, 1, 0, 2'd2); expect_prg("R2", 1, 16'h0000);
        cpu_step(16'hFFFF, 1, 0, 2'd2); expect_prg("R2", 1, 16'h7FFF);
        cpu_step(16'hC123, 1, 0, 2'd2); expect_prg("R2", 1, 16'h4123);
        cpu_step(16'hE555, 1, 0, 2'd3); expect_prg("R2", 1, 16'h6555);
    endtask

    task automatic t_prg_single;
        cpu_step(16'h8000, 1, 0, 2'd1); expect_prg("R3", 1, 16'h0000);
        cpu_step(16'hC000, 1, 0, 2'd1); expect_prg("R3", 1, 16'h0000);
        cpu_step(16'hFFFF, 1, 0, 2'd1); expect_prg("R3", 1, 16'h3FFF);
        cpu_step(16'hC123, 1, 0, 2'd1); expect_prg("R3", 1, 16'h0123);
        cpu_step(16'hE555, 1, 0, 2'd0); expect_prg("R3", 1, 16'h2555);
    endtask

    task automatic t_prg_window;
        cpu_step(16'h7FFF, 1, 0, 2'd2); expect_prg("R1", 0, 0);
        cpu_step(16'h0000, 1, 1, 2'd2); expect_prg("R1", 0, 0);
        cpu_step(16'hA000, 0, 0, 2'd2); expect_prg("R8", 0, 0);
    endtask

    task automatic t_prg_write;
        cpu_step(16'h9ABC, 0, 1, 2'd2); expect_prg("R4", 1, 16'h1ABC);
        cpu_step(16'h9ABC, 1, 0, 2'd2); expect_prg("R4", 1, 16'h1ABC);
        cpu_step(16'hDABC, 0, 1, 2'd1); expect_prg("R4", 1, 16'h1ABC);
    endtask

    task automatic t_chr_read;
        vid_step(14'h0000, 1, 0); expect_chr("R5", 1, 16'h0000);
        vid_step(14'h1FFF, 1, 0); expect_chr("R5", 1, 16'h1FFF);
        vid_step(14'h0ABC, 1, 0); expect_chr("R5", 1, 16'h0ABC);
        vid_step(14'h0ABC, 0, 0); expect_chr("R8", 0, 0);
    endtask

    task automatic t_chr_write;
        vid_step(14'h0100, 0, 1); expect_chr("R6", 0, 0);
        vid_step(14'h0100, 1, 1); expect_chr("R6", 0, 0);
    endtask

    task automatic t_chr_above;
        vid_step(14'h2000, 1, 0); expect_chr("R7", 0, 0);
        vid_step(14'h3F00, 1, 0); expect_chr("R7", 0, 0);
        vid_step(14'h3FFF, 1, 0); expect_chr("R7", 0, 0);
    endtask

    task automatic t_both_sides;
        @(negedge clk);
        cpu_addr = 16'hF00D; cpu_rd = 1'b1; cpu_wr = 1'b0; prg_bank_cnt = 2'd1;
        vid_addr = 14'h1234; vid_rd = 1'b1; vid_wr = 1'b0;
        @(negedge clk);
        expect_prg("R3", 1, 16'h300D);
        expect_chr("R5", 1, 16'h1234);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_prg_double();
        t_prg_single();
        t_prg_window();
        t_prg_write();
        t_chr_read();
        t_chr_write();
        t_chr_above();
        t_both_sides();
        finish_run();
    end

    initial begin
        #(20 * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule